// File: doc/BRIEF.md
# Double-Buffered 12-bit Pulse Timer

This block is an up-counting period timer that drives one pulse output. Two 12-bit values set its waveform: a period value, at which the counter returns to zero and the output goes high, and a duty value, at which the output goes low. Each value sits behind a buffer register, and a byte-wide write port loads the buffers one half at a time. While the timer is stopped, a buffer write reaches the active value at once. While it runs, the buffers are copied to the active values only when a period ends, so a new period or duty setting never cuts the current cycle short.

The timer runs either continuously (free-running pulse-width mode) or as a one-shot that stops itself after one full period. A separate count-enable input gates each count, which lets a prescaler outside the block set the count rate. Every period end sets a sticky flag. The flag raises the interrupt output when the interrupt enable bit is set.

Top module: `pulse_timer_top`

## Requirements
- R1: After reset, pulse_out and irq are low, all control bits and both period and duty values are zero, the counter is zero, and rd_data is zero.
- R2: Byte addresses for writes: 0 is control (bit 0 run, bit 1 one-shot, bit 2 interrupt enable), 1 is the flag (bit 0), 2 is period bits 11:8 (from data bits 3:0, data bits 7:4 ignored), 3 is period bits 7:0, 4 is duty bits 11:8 (from data bits 3:0), and 5 is duty bits 7:0. Reads return the result one clock after rd_addr is applied: 0 gives control, 1 gives the flag in bit 0, 6 gives counter bits 7:0, and 7 gives counter bits 12:8 in bits 4:0. Period and duty read as zero.
- R3: The 13-bit counter advances by one only on clocks where run is set and cnt_en is high, and otherwise holds. While run is clear, it is zero from the clock after run clears.
- R4: A period match occurs on an advancing clock when the counter equals the active period plus one. That clock resets the counter to zero and sets pulse_out high. A counter equal to the period alone causes no match, and a period of 0xFFF matches at a count of 0x1000.
- R5: While run is clear, a buffer write reaches the active period or duty value on the same clock.
- R6: While run is set, buffer writes leave the active period and duty unchanged until the next period match, which copies both buffers into the active values.
- R7: On an advancing clock where the counter equals the active duty value, pulse_out goes low. If a period match happens on the same clock, pulse_out goes high instead.
- R8: Writing control with run set while the timer is stopped clears pulse_out and starts counting from zero. The same write while the timer runs does not restart it and leaves pulse_out unchanged.
- R9: In one-shot mode the period match clears the run bit, the counter then stays at zero, and pulse_out stays high. In continuous mode the timer keeps running.
- R10: Each period match sets the flag. Writing flag bit 0 as 1 clears it, and writing 0 leaves it set. irq equals the flag ANDed with the interrupt enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read byte address |
| rd_data | output | 8 | Registered read data |
| cnt_en | input | 1 | Count enable for the current clock |
| pulse_out | output | 1 | Pulse output |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The hardest situation to reach is a buffer write landing while the timer runs, followed by proof that the old period and duty still govern the cycle in progress and the new ones govern the next cycle. The stimulus holds cnt_en low to freeze the counter at chosen counts. This lets it write the buffers mid-period, read the counter, and then release single counts to observe pulse_out just before and just after each match. Setting the duty equal to the period plus one brings the set-over-clear collision about in the same way. A maximum period exercises the 13th counter bit.

// File: rtl/pulse_tmr_pkg.sv
package pulse_tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_FLAG    = 3'd1,
    A_PRD_HI  = 3'd2,
    A_PRD_LO  = 3'd3,
    A_DUTY_HI = 3'd4,
    A_DUTY_LO = 3'd5,
    A_CNT_LO  = 3'd6,
    A_CNT_HI  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic ien;
    logic oneshot;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pt_cmp_bank.sv
module pt_cmp_bank #(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  input  logic          running,
  input  logic          xfer,
  output logic [CW-1:0] act
);
  localparam int HW = CW - DW;

  logic [CW-1:0] buf_q;
  logic [CW-1:0] buf_nx;

  always_comb begin
    buf_nx = buf_q;
    if (wr_lo) buf_nx[DW-1:0] = wr_data;
    if (wr_hi) buf_nx[CW-1:DW] = wr_data[HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act   <= '0;
    end else begin
      buf_q <= buf_nx;
      if (!running)  act <= buf_nx;
      else if (xfer) act <= buf_q;
    end
  end
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pulse_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic       wr_flag,
  input  logic [2:0] ctrl_data,
  input  logic       clr_evt,
  output ctrl_t      ctrl,
  output logic       flag,
  output logic       start
);
  assign start = wr_ctrl && ctrl_data[0] && !ctrl.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_ctrl)                     ctrl <= ctrl_t'(ctrl_data);
      else if (clr_evt && ctrl.oneshot) ctrl.run <= 1'b0;
      if (clr_evt)                     flag <= 1'b1;
      else if (wr_flag && ctrl_data[0]) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int CW = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        cnt_en,
  input  logic [CW-1:0] prd_act,
  input  logic [CW-1:0] duty_act,
  output logic [CW:0] cnt,
  output logic        clr_evt,
  output logic        duty_evt
);
  logic tick;
  logic clr_hit;

  assign tick     = run && cnt_en;
  assign clr_hit  = (cnt == ({1'b0, prd_act} + (CW+1)'(1)));
  assign clr_evt  = tick && clr_hit;
  assign duty_evt = tick && !clr_hit && (cnt == {1'b0, duty_act});

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (clr_evt) cnt <= '0;
    else if (tick)    cnt <= cnt + (CW+1)'(1);
  end
endmodule

// File: rtl/pt_pulse.sv
module pt_pulse (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clr_evt,
  input  logic duty_evt,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst || start)  pulse <= 1'b0;
    else if (clr_evt)  pulse <= 1'b1;
    else if (duty_evt) pulse <= 1'b0;
  end
endmodule

// File: rtl/pulse_timer_top.sv
module pulse_timer_top
  import pulse_tmr_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          cnt_en,
  output logic          pulse_out,
  output logic          irq
);
  localparam int PADH = 2*DW - CW - 1;

  ctrl_t         ctrl;
  logic          run_q;
  logic          flag_q;
  logic          start;
  logic          clr_evt;
  logic          duty_evt;
  logic [CW:0]   cnt_q;
  logic [CW-1:0] prd_act;
  logic [CW-1:0] duty_act;
  logic          wr_ctrl;
  logic          wr_flag;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_flag = wr_en && (wr_addr == A_FLAG);
  assign run_q   = ctrl.run;

  pt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_flag(wr_flag),
    .ctrl_data(wr_data[2:0]), .clr_evt(clr_evt),
    .ctrl(ctrl), .flag(flag_q), .start(start)
  );

  pt_cmp_bank #(.CW(CW), .DW(DW)) u_prd (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && (wr_addr == A_PRD_LO)),
    .wr_hi(wr_en && (wr_addr == A_PRD_HI)),
    .wr_data(wr_data), .running(run_q), .xfer(clr_evt), .act(prd_act)
  );

  pt_cmp_bank #(.CW(CW), .DW(DW)) u_duty (
    .clk(clk), .rst(rst),
    .wr_lo(wr_en && (wr_addr == A_DUTY_LO)),
    .wr_hi(wr_en && (wr_addr == A_DUTY_HI)),
    .wr_data(wr_data), .running(run_q), .xfer(clr_evt), .act(duty_act)
  );

  pt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .cnt_en(cnt_en),
    .prd_act(prd_act), .duty_act(duty_act),
    .cnt(cnt_q), .clr_evt(clr_evt), .duty_evt(duty_evt)
  );

  pt_pulse u_pulse (
    .clk(clk), .rst(rst), .start(start),
    .clr_evt(clr_evt), .duty_evt(duty_evt), .pulse(pulse_out)
  );

  assign irq = flag_q && ctrl.ien;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_addr_e'(rd_addr))
        A_CTRL:   rd_data <= {{(DW-3){1'b0}}, ctrl.ien, ctrl.oneshot, ctrl.run};
        A_FLAG:   rd_data <= {{(DW-1){1'b0}}, flag_q};
        A_CNT_LO: rd_data <= cnt_q[DW-1:0];
        A_CNT_HI: rd_data <= {{PADH{1'b0}}, cnt_q[CW:DW]};
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pt_checker.sv
module pt_checker
  import pulse_tmr_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          cnt_en,
  input logic          run,
  input logic          oneshot,
  input logic          flag,
  input logic [CW:0]   cnt,
  input logic [CW-1:0] prd_act,
  input logic [CW-1:0] duty_act,
  input logic          clr_evt,
  input logic          duty_evt,
  input logic          pulse_out
);
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_en) |=> (cnt == $past(cnt)));

  p_stop_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  p_match_set_r4: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> (pulse_out && cnt == '0));

  p_pass_thru_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && wr_en && wr_addr == A_PRD_LO) |=> (prd_act[DW-1:0] == $past(wr_data)));

  p_hold_active_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !clr_evt) |=> ($stable(prd_act) && $stable(duty_act)));

  p_duty_clear_r7: assert property (@(posedge clk) disable iff (rst)
    duty_evt |=> !pulse_out);

  p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && oneshot && !(wr_en && wr_addr == A_CTRL)) |=> !run);

  p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> flag);
endmodule

bind pulse_timer_top pt_checker #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt_en(cnt_en), .run(run_q), .oneshot(ctrl.oneshot), .flag(flag_q),
  .cnt(cnt_q), .prd_act(prd_act), .duty_act(duty_act),
  .clr_evt(clr_evt), .duty_evt(duty_evt), .pulse_out(pulse_out)
);

// File: tb/tb_pulse_timer_top.sv
`timescale 1ns/1ps
module tb_pulse_timer_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cnt_en = 1'b0;
  logic       pulse_out;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    string req;
    int    sel;
    int    val;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  pulse_timer_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_en(cnt_en),
    .pulse_out(pulse_out), .irq(irq)
  );

  // monitor: pops expected items and compares with sampled outputs
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      int act;
      e = exp_q.pop_front();
      case (e.sel)
        0:       act = int'(pulse_out);
        1:       act = int'(irq);
        default: act = int'(rd_data);
      endcase
      n_checks++;
      if (act != e.val) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", e.req, e.sel, act, e.val);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input string req, input int sel, input int val);
    exp_t e;
    e.req = req; e.sel = sel; e.val = val;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input string req, input int val);
    rd_addr = a;
    cyc(1);
    push(req, 2, val);
  endtask

  task automatic run_cnt(input int n);
    cnt_en = 1'b1;
    cyc(n);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    push("R1", 0, 0);
    push("R1", 1, 0);
    rd_exp(3'd0, "R1", 0);
    rd_exp(3'd6, "R1", 0);

    // stopped writes pass straight through
    wr(3'd3, 8'd5);
    wr(3'd2, 8'hF0);
    wr(3'd5, 8'd2);
    rd_exp(3'd3, "R2", 0);
    wr(3'd0, 8'h01);
    cyc(3);
    rd_exp(3'd6, "R3", 0);
    run_cnt(6);
    push("R4", 0, 0);
    rd_exp(3'd6, "R5", 6);
    run_cnt(1);
    push("R4", 0, 1);
    rd_exp(3'd6, "R4", 0);
    rd_exp(3'd1, "R10", 1);
    push("R10", 1, 0);
    run_cnt(2);
    push("R7", 0, 1);
    run_cnt(1);
    push("R7", 0, 0);

    // buffered writes while running
    wr(3'd3, 8'd9);
    wr(3'd5, 8'd4);
    run_cnt(3);
    push("R6", 0, 0);
    run_cnt(1);
    push("R6", 0, 1);
    run_cnt(4);
    push("R6", 0, 1);
    run_cnt(1);
    push("R6", 0, 0);
    run_cnt(5);
    rd_exp(3'd6, "R6", 10);
    run_cnt(1);
    push("R4", 0, 1);

    // interrupt enable, no restart while running
    wr(3'd0, 8'h05);
    push("R10", 1, 1);
    push("R8", 0, 1);
    wr(3'd1, 8'h00);
    push("R10", 1, 1);
    wr(3'd1, 8'h01);
    push("R10", 1, 0);

    // set wins over clear on the same count
    wr(3'd5, 8'd10);
    run_cnt(11);
    push("R10", 1, 1);
    run_cnt(10);
    push("R7", 0, 1);
    run_cnt(1);
    push("R7", 0, 1);
    rd_exp(3'd6, "R7", 0);

    // stop zeroes the counter
    run_cnt(3);
    wr(3'd0, 8'h00);
    cnt_en = 1'b1;
    cyc(2);
    rd_exp(3'd6, "R3", 0);
    cnt_en = 1'b0;
    push("R10", 1, 0);

    // one-shot
    wr(3'd3, 8'd3);
    wr(3'd5, 8'd1);
    wr(3'd0, 8'h03);
    push("R8", 0, 0);
    run_cnt(4);
    push("R9", 0, 0);
    rd_exp(3'd0, "R9", 3);
    cnt_en = 1'b1;
    cyc(4);
    cnt_en = 1'b0;
    push("R9", 0, 1);
    rd_exp(3'd0, "R9", 2);
    rd_exp(3'd6, "R9", 0);

    // upper nibble, counter high byte
    wr(3'd2, 8'hF1);
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h01);
    run_cnt(257);
    push("R7", 0, 0);
    rd_exp(3'd7, "R2", 1);
    rd_exp(3'd6, "R2", 1);
    run_cnt(1);
    push("R4", 0, 1);

    // maximum period uses the 13th counter bit
    wr(3'd0, 8'h00);
    cyc(1);
    wr(3'd2, 8'h0F);
    wr(3'd3, 8'hFF);
    wr(3'd0, 8'h01);
    run_cnt(4096);
    push("R4", 0, 0);
    rd_exp(3'd7, "R4", 16);
    run_cnt(1);
    push("R4", 0, 1);

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule